// File: doc/BRIEF.md
# Normal-Basis Field Inversion Sequencer

This block inverts a nonzero element of GF(2^N) that is held in a normal basis. It uses Fermat's little theorem, a^-1 = (a^(2^(N-1)-1))^2. It builds the inner power with an addition chain over the binary expansion of N-1. In a normal basis a squaring is a cyclic rotation, so every squaring takes one clock. The field multiplications, of which there are only a logarithmic number, go to an external multiplier through a start/done handshake.

The chain walks the bits of N-1 from the second-highest bit down to the lowest. It keeps an accumulator b = a^(2^k - 1):

- For each bit, k copies of b are squared by rotation and the result is multiplied by b, which doubles k.
- If that bit is one, b is squared once more and multiplied by the original input, which adds one to k.

A final rotation of b gives the inverse. A zero input returns zero with an error flag and runs no chain.

Bit i of a field vector is the coefficient of the basis element beta^(2^i). A squaring therefore moves bit i to bit i+1 and bit N-1 to bit 0. The field's one is the all-ones vector.

Top module: `nb_inverse_seq`

## Requirements
- R1: After reset, res, err, done and mul_start are all 0.
- R2: For every nonzero input a, the product a*res equals the all-ones vector when done pulses. The product is taken in the type-II optimal normal basis, where bit i is the coefficient of beta^(2^i).
- R3: A start with a = 0 in idle gives done = 1, err = 1 and res = 0 one cycle later, with no multiplier request.
- R4: One nonzero inversion issues exactly floor(log2(N-1)) + popcount(N-1) - 1 multiplier requests. For N = 5 that is 2.
- R5: mul_start is a one-cycle pulse. mul_x and mul_y stay stable from the request until mul_done is seen.
- R6: start is ignored while an inversion is running. The result belongs to the input taken at the accepted start, and the request count is unchanged.
- R7: done is a one-cycle pulse. res and err change only in the done cycle and hold until the next completion.
- R8: The sequencer waits any number of cycles, at least one, for mul_done after a request.
- R9: A start presented in the cycle where done is high is accepted, so back-to-back inversions are possible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an inversion of a |
| a | input | N | Operand in normal basis |
| res | output | N | Inverse, held until next completion |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last operand was zero |
| mul_start | output | 1 | Multiplier request pulse |
| mul_x | output | N | First multiplier operand |
| mul_y | output | N | Second multiplier operand |
| mul_done | input | 1 | Multiplier result valid |
| mul_p | input | N | Multiplier product |

## Verification
Two things can fall in the same cycle. The first is a new start landing while the sequencer is busy, including the cycle in which the external product returns. The bench toggles start, with a changing operand, on every cycle of a run. It then judges that the result still inverts the original operand and that the request count is unchanged. The second is a start landing in the very cycle done pulses. The bench keeps start high across a completion and checks that the second inversion runs and is correct. The product model uses several latencies so that returns coincide with different chain positions.

// File: rtl/nb_inverse_seq.sv
module nb_inverse_seq #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [N-1:0] a,
  output logic [N-1:0] res,
  output logic         done,
  output logic         err,
  output logic         mul_start,
  output logic [N-1:0] mul_x,
  output logic [N-1:0] mul_y,
  input  logic         mul_done,
  input  logic [N-1:0] mul_p
);

  localparam int MW = $clog2(N) + 1;
  localparam int TOP = $clog2(N) - 1;
  localparam logic [MW-1:0] MV = MW'(N - 1);
  localparam logic [MW-1:0] SH0 = MV << (MW - TOP);

  typedef enum logic [1:0] {S_IDLE, S_NEXT, S_SQR, S_WAIT} st_t;
  st_t st;

  logic [N-1:0]  acc, tmp, opa;
  logic [MW-1:0] k, cnt, idx, pat;
  logic          addph;

  function automatic logic [N-1:0] rotl(input logic [N-1:0] v);
    return {v[N-2:0], v[N-1]};
  endfunction

  assign mul_x = tmp;
  assign mul_y = addph ? opa : acc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      acc <= '0; tmp <= '0; opa <= '0;
      k <= '0; cnt <= '0; idx <= '0; pat <= '0;
      addph <= 1'b0;
      res <= '0; done <= 1'b0; err <= 1'b0; mul_start <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          if (a == '0) begin
            res <= '0;
            err <= 1'b1;
            done <= 1'b1;
          end else begin
            opa <= a;
            acc <= a;
            k <= MW'(1);
            idx <= MW'(TOP);
            pat <= SH0;
            st <= S_NEXT;
          end
        end
        S_NEXT: begin
          if (idx == '0) begin
            res <= rotl(acc);
            err <= 1'b0;
            done <= 1'b1;
            st <= S_IDLE;
          end else begin
            tmp <= acc;
            cnt <= k;
            addph <= 1'b0;
            st <= S_SQR;
          end
        end
        S_SQR: begin
          if (cnt != '0) begin
            tmp <= rotl(tmp);
            cnt <= cnt - 1'b1;
          end else begin
            mul_start <= 1'b1;
            st <= S_WAIT;
          end
        end
        S_WAIT: begin
          mul_start <= 1'b0;
          if (mul_done) begin
            acc <= mul_p;
            if (!addph && pat[MW-1]) begin
              k <= k << 1;
              tmp <= mul_p;
              cnt <= MW'(1);
              addph <= 1'b1;
              st <= S_SQR;
            end else begin
              k <= addph ? k + 1'b1 : k << 1;
              addph <= 1'b0;
              idx <= idx - 1'b1;
              pat <= pat << 1;
              st <= S_NEXT;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_zero_input_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && start && a == '0) |=> (done && err && res == '0 && !mul_start));

  p_req_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mul_start |=> !mul_start);

  p_operands_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT && !mul_done) |=> ($stable(mul_x) && $stable(mul_y)));

  p_result_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(res) && $stable(err)));

  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> !mul_start);

  p_done_no_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mul_start);

endmodule

// File: tb/nb_inverse_seq_tb_top.sv
`timescale 1ns/1ps
module nb_inverse_seq_tb_top;
  localparam int N = 5;
  localparam logic [N-1:0] ONE = '1;
  localparam int NV = 8;
  localparam logic [7:0] VEC [0:NV-1] = '{
    {5'h01, 3'd1}, {5'h1f, 3'd2}, {5'h10, 3'd3}, {5'h15, 3'd1},
    {5'h0a, 3'd4}, {5'h03, 3'd1}, {5'h1e, 3'd5}, {5'h07, 3'd2}
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [N-1:0] a_in = '0;
  logic [N-1:0] res, mul_x, mul_y, mul_p;
  logic done, err, mul_start, mul_done;
  int total = 0, bad = 0, nmul = 0, cur_lat = 1;

  always #2.5 clk = ~clk;

  nb_inverse_seq #(.N(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .a(a_in), .res(res), .done(done),
    .err(err), .mul_start(mul_start), .mul_x(mul_x), .mul_y(mul_y),
    .mul_done(mul_done), .mul_p(mul_p));

  function automatic logic [N-1:0] nbmul(input logic [N-1:0] x, input logic [N-1:0] y);
    logic [10:0] px, py, c;
    int e [0:N-1];
    logic [N-1:0] r;
    px = '0; py = '0; c = '0;
    e[0] = 1;
    for (int i = 1; i < N; i++) e[i] = (e[i-1] * 2) % 11;
    for (int i = 0; i < N; i++) begin
      if (x[i]) begin px[e[i]] = ~px[e[i]]; px[11-e[i]] = ~px[11-e[i]]; end
      if (y[i]) begin py[e[i]] = ~py[e[i]]; py[11-e[i]] = ~py[11-e[i]]; end
    end
    for (int i = 0; i < 11; i++)
      for (int j = 0; j < 11; j++)
        if (px[i] && py[j]) c[(i+j)%11] = ~c[(i+j)%11];
    for (int i = 0; i < N; i++) r[i] = c[e[i]] ^ c[0];
    return r;
  endfunction

  function automatic logic [N-1:0] ref_inv(input logic [N-1:0] x);
    logic [N-1:0] r;
    r = '0;
    for (int b = 1; b < (1 << N); b++)
      if (nbmul(x, N'(b)) == ONE) r = N'(b);
    return r;
  endfunction

  function automatic int exp_muls();
    int m, lg;
    m = N - 1; lg = 0;
    while ((m >> (lg + 1)) != 0) lg++;
    return lg + $countones(m) - 1;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    mul_done = 1'b0; mul_p = '0;
    forever begin
      @(negedge clk);
      if (mul_start) begin
        logic [N-1:0] x, y;
        nmul++;
        x = mul_x; y = mul_y;
        if (cur_lat > 1) repeat (cur_lat - 1) @(negedge clk);
        mul_p = nbmul(x, y);
        mul_done = 1'b1;
        @(negedge clk);
        mul_done = 1'b0;
      end
    end
  end

  task automatic wait_done(input bit noisy, input logic [N-1:0] av, output bit ok);
    int w;
    w = 0;
    while (!done && w < 3000) begin
      if (noisy) begin start = w[0]; a_in = av ^ N'(w); end
      @(negedge clk);
      w++;
    end
    ok = done;
    if (!ok) check("R8 timeout", 0, 1);
  endtask

  task automatic run(input logic [N-1:0] av, input int lat, input bit noisy, input string req);
    bit ok;
    cur_lat = lat; nmul = 0;
    @(negedge clk);
    a_in = av; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(noisy, av, ok);
    start = 1'b0;
    if (ok) begin
      check({req, " R2 inverse"}, res, ref_inv(av));
      check({req, " R2 product"}, nbmul(av, res), ONE);
      check({req, " R4 muls"}, nmul, exp_muls());
      check({req, " err"}, err, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit ok;
    repeat (3) @(negedge clk);
    check("R1 res", res, 0);
    check("R1 err", err, 0);
    check("R1 done", done, 0);
    check("R1 mul_start", mul_start, 0);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++)
      run(VEC[v][7:3], int'(VEC[v][2:0]), 1'b0, "R8 table");

    for (int v = 1; v < (1 << N); v++)
      run(N'(v), (v % 3) + 1, 1'b0, "R2 sweep");

    // R3 zero operand
    nmul = 0;
    @(negedge clk); a_in = '0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    check("R3 done", done, 1);
    check("R3 err", err, 1);
    check("R3 res", res, 0);
    @(negedge clk);
    check("R3 no muls", nmul, 0);
    check("R7 pulse", done, 0);

    // R6 start chatter while busy
    run(5'h0b, 3, 1'b1, "R6 busy start");
    run(5'h12, 1, 1'b1, "R6 busy start");

    // R7 hold after completion
    run(5'h09, 2, 1'b0, "R7");
    repeat (4) @(negedge clk);
    check("R7 done low", done, 0);
    check("R7 res held", res, ref_inv(5'h09));

    // R9 back-to-back: start high through done
    cur_lat = 2; nmul = 0;
    @(negedge clk); a_in = 5'h06; start = 1'b1;
    @(negedge clk);
    wait_done(1'b0, 5'h06, ok);
    check("R9 first", res, ref_inv(5'h06));
    a_in = 5'h19;
    @(negedge clk); start = 1'b0;
    check("R9 accepted busy", done, 0);
    wait_done(1'b0, 5'h19, ok);
    check("R9 second", res, ref_inv(5'h19));
    check("R9 second product", nbmul(5'h19, res), ONE);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule